// File: doc/BRIEF.md
# Programmable Active Video Window Generator

This block drives one flag that marks which pixels of the outgoing picture carry valid video. There are two ways to produce it. In follow mode the flag is an incoming active-video strobe delayed through a tapped line of up to 15 stages. The delay is chosen so that the flag lines up with a pixel data path of matching latency. In window mode the strobe input is ignored and the flag marks a programmed rectangle. The rectangle is set by a first pixel, a pixel count, a first line and a last line. A pixel counter cleared by the line pulse and a line counter cleared by the field pulse give each pixel its position.

Both modes pass through a common output stage. In that stage the flag can be advanced by 0 to 3 clocks ahead of its nominal position, and its polarity can be inverted. With an advance of zero, the flag for window position (pixel, line) appears four clocks after the edge that set the counters to that position. All settings are static inputs that are held steady while the block runs. Changes are made with reset asserted.

Top module: `avwin_gen`

## Requirements
- R1: While `rst_n` is low, `flag_o` shows the inactive level, equal to `cfg_invert`.
- R2: In window mode, the horizontal part of the window is true for pixel counts p with `cfg_hstart` <= p < `cfg_hstart` + `cfg_hlen`. A length of zero never opens the window.
- R3: In window mode, the vertical part of the window is true for line counts l with `cfg_vstart` <= l <= `cfg_vstop`. If `cfg_vstop` < `cfg_vstart`, the window never opens.
- R4: A clock edge that samples `hsync_i` high sets the pixel count to 0. Every other edge increments it, and it holds once it reaches its maximum. An edge that samples `fsync_i` high sets the line count to 0, and this takes priority. Otherwise an edge that samples `hsync_i` high increments the line count, and it also holds at its maximum.
- R5: In follow mode (`cfg_win_mode` = 0), `flag_o` after clock edge t equals `act_i` as sampled at edge t - 3 + `cfg_lead` - `cfg_delay`, XOR `cfg_invert`. Before reset the strobe is taken as 0.
- R6: In follow mode, every value of `cfg_delay` from 0 to 15 adds exactly that many clocks of delay.
- R7: In window mode (`cfg_win_mode` = 1), `flag_o` after edge t reflects the window test on the counts left by edge t - 4 + `cfg_lead`. `cfg_lead` ranges over 0 to 3.
- R8: `cfg_invert` = 1 inverts `flag_o` in both modes.
- R9: In window mode, `act_i` has no effect on `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line start pulse, one clock wide |
| fsync_i | input | 1 | Field start pulse, one clock wide |
| act_i | input | 1 | Incoming active-video strobe |
| cfg_win_mode | input | 1 | 1: window mode, 0: follow mode |
| cfg_invert | input | 1 | Output polarity invert |
| cfg_delay | input | 4 | Follow-mode delay in clocks, 0 to 15 |
| cfg_lead | input | 2 | Advance of the flag in clocks, 0 to 3 |
| cfg_hstart | input | PW | First active pixel count |
| cfg_hlen | input | PW | Number of active pixels per line |
| cfg_vstart | input | LW | First active line count |
| cfg_vstop | input | LW | Last active line count |
| flag_o | output | 1 | Active-video flag |

## Verification
If a counter is off by one, the window edges at the port move by a whole pixel or a whole line. That error shows up at the first window boundary, which comes within one line of the field start. If the tap selection or the advance line is wrong, the whole flag waveform shifts by a constant number of clocks. In follow mode a pseudo-random strobe exposes such a shift within a few clocks. A polarity fault is visible as soon as reset is released.

// File: rtl/avwin_pkg.sv
package avwin_pkg;
  localparam int CW = 16;
  typedef logic [CW-1:0] cnt_t;

  // half-open span: first <= pos < first + count, free of overflow
  function automatic logic span_open(cnt_t pos, cnt_t first, cnt_t count);
    return (pos >= first) && ((pos - first) < count);
  endfunction

  // closed span: first <= pos <= last
  function automatic logic span_closed(cnt_t pos, cnt_t first, cnt_t last);
    return (pos >= first) && (pos <= last);
  endfunction
endpackage

// File: rtl/avwin_counters.sv
module avwin_counters #(
  parameter int PW = 12,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_i,
  input  logic          fsync_i,
  output logic [PW-1:0] px_o,
  output logic [LW-1:0] ln_o
);
  localparam logic [PW-1:0] PMAX = '1;
  localparam logic [LW-1:0] LMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_o <= '0;
    end else if (hsync_i) begin
      px_o <= '0;
    end else if (px_o != PMAX) begin
      px_o <= px_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_o <= '0;
    end else if (fsync_i) begin
      ln_o <= '0;
    end else if (hsync_i && ln_o != LMAX) begin
      ln_o <= ln_o + 1'b1;
    end
  end
endmodule

// File: rtl/avwin_tapdly.sv
module avwin_tapdly #(
  parameter int DEPTH = 15,
  localparam int SELW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [SELW-1:0] sel,
  output logic            dout
);
  logic [DEPTH-1:0] stg;
  logic [SELW-1:0]  idx;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign idx = sel - 1'b1;

  always_comb begin
    if (sel == '0)
      dout = din;
    else if (int'(sel) > DEPTH)
      dout = stg[DEPTH-1];
    else
      dout = stg[idx];
  end
endmodule

// File: rtl/avwin_gen.sv
module avwin_gen #(
  parameter int PW       = 12,
  parameter int LW       = 10,
  parameter int DLY_MAX  = 15,
  parameter int LEAD_MAX = 3,
  localparam int DLW = $clog2(DLY_MAX + 1),
  localparam int LDW = $clog2(LEAD_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hsync_i,
  input  logic           fsync_i,
  input  logic           act_i,
  input  logic           cfg_win_mode,
  input  logic           cfg_invert,
  input  logic [DLW-1:0] cfg_delay,
  input  logic [LDW-1:0] cfg_lead,
  input  logic [PW-1:0]  cfg_hstart,
  input  logic [PW-1:0]  cfg_hlen,
  input  logic [LW-1:0]  cfg_vstart,
  input  logic [LW-1:0]  cfg_vstop,
  output logic           flag_o
);
  import avwin_pkg::*;

  // named internal events, observed by the bound checker
  logic [PW-1:0]  px_cnt;
  logic [LW-1:0]  ln_cnt;
  logic           win_h;
  logic           win_v;
  logic           follow_flag;
  logic           raw_flag;
  logic           pre_flag;
  logic           flag_q;
  logic [LDW-1:0] lead_tap;

  avwin_counters #(.PW(PW), .LW(LW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync_i (hsync_i),
    .fsync_i (fsync_i),
    .px_o    (px_cnt),
    .ln_o    (ln_cnt)
  );

  assign win_h = span_open(cnt_t'(px_cnt), cnt_t'(cfg_hstart), cnt_t'(cfg_hlen));
  assign win_v = span_closed(cnt_t'(ln_cnt), cnt_t'(cfg_vstart), cnt_t'(cfg_vstop));

  avwin_tapdly #(.DEPTH(DLY_MAX)) u_follow (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (act_i),
    .sel   (cfg_delay),
    .dout  (follow_flag)
  );

  assign raw_flag = cfg_win_mode ? (win_h && win_v) : follow_flag;

  // a larger advance taps earlier in the alignment line
  assign lead_tap = LDW'(LEAD_MAX) - cfg_lead;

  avwin_tapdly #(.DEPTH(LEAD_MAX)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_flag),
    .sel   (lead_tap),
    .dout  (pre_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= pre_flag;
  end

  assign flag_o = flag_q ^ cfg_invert;
endmodule

// File: rtl/avwin_chk.sv
module avwin_chk #(
  parameter int PW  = 12,
  parameter int LW  = 10,
  parameter int DLW = 4,
  parameter int LDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hsync_i,
  input logic           fsync_i,
  input logic           act_i,
  input logic           cfg_win_mode,
  input logic           cfg_invert,
  input logic [DLW-1:0] cfg_delay,
  input logic [LDW-1:0] cfg_lead,
  input logic [PW-1:0]  cfg_hlen,
  input logic [LW-1:0]  cfg_vstart,
  input logic [LW-1:0]  cfg_vstop,
  input logic [PW-1:0]  px_cnt,
  input logic [LW-1:0]  ln_cnt,
  input logic           win_h,
  input logic           win_v,
  input logic           flag_o
);
  localparam logic [PW-1:0] PMAX = '1;

  // R4
  px_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |=> px_cnt == '0);

  // R4
  px_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_i && px_cnt != PMAX) |=> px_cnt == PW'($past(px_cnt) + 1'b1));

  // R4
  ln_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> ln_cnt == '0);

  // R2
  hlen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hlen == '0 |-> !win_h);

  // R3
  vorder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vstop < cfg_vstart |-> !win_v);

  // R5
  follow_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cfg_win_mode && cfg_lead == '1 && cfg_delay == '0
     && $stable(cfg_win_mode) && $stable(cfg_lead) && $stable(cfg_delay)
     && $stable(cfg_invert))
    |-> flag_o == ($past(act_i) ^ cfg_invert));
endmodule

bind avwin_gen avwin_chk #(.PW(PW), .LW(LW), .DLW(DLW), .LDW(LDW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hsync_i      (hsync_i),
  .fsync_i      (fsync_i),
  .act_i        (act_i),
  .cfg_win_mode (cfg_win_mode),
  .cfg_invert   (cfg_invert),
  .cfg_delay    (cfg_delay),
  .cfg_lead     (cfg_lead),
  .cfg_hlen     (cfg_hlen),
  .cfg_vstart   (cfg_vstart),
  .cfg_vstop    (cfg_vstop),
  .px_cnt       (px_cnt),
  .ln_cnt       (ln_cnt),
  .win_h        (win_h),
  .win_v        (win_v),
  .flag_o       (flag_o)
);

// File: tb/avwin_gen_bench.sv
module avwin_gen_bench;
  localparam int PW    = 8;
  localparam int LW    = 6;
  localparam int LINE  = 16;
  localparam int FIELD = 10;
  localparam int PMAXI = (1 << PW) - 1;
  localparam int LMAXI = (1 << LW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hsync_i = 1'b0, fsync_i = 1'b0, act_i = 1'b0;
  logic          cfg_win_mode = 1'b0, cfg_invert = 1'b0;
  logic [3:0]    cfg_delay = '0;
  logic [1:0]    cfg_lead = '0;
  logic [PW-1:0] cfg_hstart = '0, cfg_hlen = '0;
  logic [LW-1:0] cfg_vstart = '0, cfg_vstop = '0;
  logic          flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit hs_h [0:511];
  bit fs_h [0:511];
  bit act_h[0:511];
  bit obs  [0:511];
  int pxm  [0:512];
  int lnm  [0:512];

  always #5 clk = ~clk;

  avwin_gen #(.PW(PW), .LW(LW)) u_avwin_gen (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .fsync_i(fsync_i),
    .act_i(act_i), .cfg_win_mode(cfg_win_mode), .cfg_invert(cfg_invert),
    .cfg_delay(cfg_delay), .cfg_lead(cfg_lead), .cfg_hstart(cfg_hstart),
    .cfg_hlen(cfg_hlen), .cfg_vstart(cfg_vstart), .cfg_vstop(cfg_vstop),
    .flag_o(flag_o)
  );

  task automatic check(input bit got, input bit exp, input string req, input int t);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", req, t, got, exp);
    end
  endtask

  task automatic run(input bit mode, input bit inv, input int dly, input int lead,
                     input int hs, input int hl, input int vs, input int ve,
                     input int n, input string req);
    logic [15:0] lfsr = 16'hACE1 ^ 16'(dly * 37 + lead * 11 + hs);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_win_mode = mode; cfg_invert = inv;
    cfg_delay = 4'(dly); cfg_lead = 2'(lead);
    cfg_hstart = PW'(hs); cfg_hlen = PW'(hl);
    cfg_vstart = LW'(vs); cfg_vstop = LW'(ve);
    repeat (2) @(negedge clk);
    check(flag_o, inv, "R1", -1);
    for (int t = 0; t < n; t++) begin
      if (t > 0) obs[t-1] = flag_o;
      rst_n = 1'b1;
      hs_h[t] = (t % LINE) == 0;
      fs_h[t] = (t % (LINE * FIELD)) == 0;
      act_h[t] = lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hsync_i = hs_h[t]; fsync_i = fs_h[t]; act_i = act_h[t];
      @(negedge clk);
    end
    obs[n-1] = flag_o;
    // positions left by each edge; slot 0 is the reset state
    pxm[0] = 0; lnm[0] = 0;
    for (int t = 0; t < n; t++) begin
      pxm[t+1] = hs_h[t] ? 0 : ((pxm[t] + 1 > PMAXI) ? PMAXI : pxm[t] + 1);
      lnm[t+1] = fs_h[t] ? 0 : (hs_h[t] ? ((lnm[t] + 1 > LMAXI) ? LMAXI : lnm[t] + 1) : lnm[t]);
    end
    for (int t = 0; t < n; t++) begin
      int k = t - 4 + lead;
      bit e;
      if (mode) begin
        // R2 R3 R7 window test on positions after edge k
        if (k < -1) e = 1'b0;
        else e = (pxm[k+1] >= hs) && (pxm[k+1] < hs + hl)
              && (lnm[k+1] >= vs) && (lnm[k+1] <= ve);
      end else begin
        // R5 R6 strobe sampled at edge k + 1 - delay
        int j = k + 1 - dly;
        e = (j < 0) ? 1'b0 : act_h[j];
      end
      check(obs[t], e ^ inv, req, t);
    end
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      // R2 R3 R7 R8 R9: act_i toggles throughout and must not matter
      run(1'b1, l[0], 5, l, 3, 5, 2, 6, 2 * LINE * FIELD + 8, "R2 R3 R7 R8 R9");
      run(1'b1, ~l[0], 0, l, 0, LINE, 0, FIELD - 1, 2 * LINE * FIELD + 8, "R4 R7 R8 R9");
      run(1'b1, l[0], 9, l, 12, 20, 4, 4, 2 * LINE * FIELD + 8, "R2 R3 R7");
      run(1'b1, l[0], 0, l, 4, 0, 0, 9, 2 * LINE * FIELD + 8, "R2 hlen zero");
      run(1'b1, ~l[0], 0, l, 1, 6, 7, 3, 2 * LINE * FIELD + 8, "R3 vstop below vstart");
      run(1'b1, l[0], 3, l, 15, 1, 9, 9, 2 * LINE * FIELD + 8, "R2 R3 R4 last pixel");
    end
    for (int d = 0; d < 16; d++) begin
      for (int l = 0; l < 4; l++) begin
        run(1'b0, 1'((d + l) % 2), d, l, 2, 3, 1, 2, 60, "R5 R6 R7 R8");
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule